// File: doc/BRIEF.md
# Local Scan Branch Controller

This block sits behind an addressable scan bridge and governs three local scan chains on one board. The bridge decodes its own instruction register and sends this block two kinds of input. One is a level that is high while the mode-programming instruction is current. The others are one-cycle update strobes for the unpark, park and return-to-wait instructions. The bridge's TAP controller state arrives as a 4-bit code. Apart from that, the block needs only the bridge select flag, the bridge TMS and TDI, and the TDO lines coming back from each local chain.

An 8-bit mode register chooses which local chains take part. Bit i enables port i. Every enabled port that has been unparked joins the active path, in series, in fixed order: port 0 first, then port 1, then port 2. A port that is parked or disabled holds its local TMS at 1, so the TAPs on that chain stay in Test-Logic-Reset. Unparking waits until the bridge TAP passes through Run-Test/Idle. This makes the local TAPs leave reset in step with the bridge. While the mode instruction is current and the bridge is selected, the mode register's shift stage is the path between TDI and the return line. When no chain is live, TDI reaches the return line through a single bypass flip-flop.

All outputs are registered on the rising edge of TCK. A synchronous, active-high reset parks every port.

Top module: `scan_branch_ctrl`

## Requirements
- R1: In the cycle after reset, every loc_tms bit is 1, every loc_tck_en bit is 0, every loc_tdi bit is 1, ret_tdo is 1, and the mode register holds 0.
- R2: When sel and ir_modesel are both high, the mode register is scanned as follows:
  - tap_state 4'h6 (Capture-DR) copies the mode into the shift stage.
  - 4'h2 (Shift-DR) shifts tdi_in in at bit 7, moving the stage towards bit 0.
  - 4'h5 (Update-DR) writes the stage into the mode.
  - ret_tdo shows the stage's bit 0 one edge later.
- R3: The mode register keeps its value whatever sel does. Only reset or tap_state 4'hF (Test-Logic-Reset) clears it.
- R4: A port whose mode bit is set is armed by upd_unpark while sel is high. It goes live at the first edge where tap_state is 4'hC (Run-Test/Idle). From the following edge onward, its loc_tck_en is 1 and its loc_tms copies tms_in with one edge of delay.
- R5: A port that is not live has loc_tms 1, loc_tck_en 0 and loc_tdi 1, and it is left out of the data path.
- R6: Live ports are chained in the order 0, 1, 2:
  - The first live port receives tdi_in one edge later.
  - Each later live port receives the previous live port's chain_tdo one edge later.
  - ret_tdo carries the last live port's chain_tdo one edge later.
- R7: When no port is live and the mode path is not active, ret_tdo equals tdi_in delayed by two edges.
- R8: upd_park or upd_wait with sel high parks every port. Tap_state 4'hF also parks every port. In each case loc_tck_en is 0 two edges later.
- R9: upd_unpark, upd_park, upd_wait and ir_modesel have no effect while sel is low.
- R10: Clearing a port's mode bit parks that port at the next edge, even while it is live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | TCK of the bridge |
| rst | input | 1 | Synchronous active-high reset |
| tap_state | input | 4 | Bridge TAP state code |
| sel | input | 1 | Bridge is addressed and selected |
| ir_modesel | input | 1 | Mode-programming instruction is current |
| upd_unpark | input | 1 | Unpark instruction update strobe |
| upd_park | input | 1 | Park-in-reset instruction update strobe |
| upd_wait | input | 1 | Return-to-wait instruction update strobe |
| tms_in | input | 1 | Bridge TMS |
| tdi_in | input | 1 | Bridge TDI |
| chain_tdo | input | 3 | TDO returned by each local chain |
| loc_tms | output | 3 | Local TMS per port |
| loc_tck_en | output | 3 | Local clock enable per port |
| loc_tdi | output | 3 | Local TDI per port |
| ret_tdo | output | 1 | Combined return data toward bridge TDO |

## Verification
Outputs fall into three timing classes:
- loc_tms, loc_tdi and the series return react one edge after their data inputs change.
- The bypass return reacts two edges after tdi_in changes.
- A strobe, a mode write or a Run-Test/Idle pass changes a port's state at one edge, and the outputs show that change at the edge after.

The bench's reference model takes each rising edge with the same register count. It compares all four outputs half a period later on every clock. Directed checks sample only after the due edge has passed.

// File: rtl/scb_pkg.sv
package scb_pkg;
  localparam logic [3:0] TAP_TLR = 4'hF;
  localparam logic [3:0] TAP_RTI = 4'hC;
  localparam logic [3:0] TAP_CDR = 4'h6;
  localparam logic [3:0] TAP_SDR = 4'h2;
  localparam logic [3:0] TAP_UDR = 4'h5;

  typedef enum logic [1:0] {
    PORT_PARKED = 2'd0,
    PORT_ARMED  = 2'd1,
    PORT_LIVE   = 2'd2
  } port_st_e;
endpackage

// File: rtl/scb_mode.sv
module scb_mode #(
  parameter int MODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tlr,
  input  logic              act,
  input  logic              cap,
  input  logic              shf,
  input  logic              upd,
  input  logic              tdi,
  output logic [MODE_W-1:0] mode_q,
  output logic              sh_lsb
);
  logic [MODE_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst || tlr)
      mode_q <= '0;
    else if (act && upd)
      mode_q <= sh_q;
  end

  always_ff @(posedge clk) begin
    if (rst)
      sh_q <= '0;
    else if (act && cap)
      sh_q <= mode_q;
    else if (act && shf)
      sh_q <= {tdi, sh_q[MODE_W-1:1]};
  end

  assign sh_lsb = sh_q[0];
endmodule

// File: rtl/scb_port.sv
module scb_port
  import scb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tlr,
  input  logic rti,
  input  logic en,
  input  logic go_unpark,
  input  logic go_park,
  input  logic tms_in,
  output logic live,
  output logic tms_q,
  output logic tck_en_q
);
  port_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (tlr || !en || go_park)
      st_d = PORT_PARKED;
    else if (go_unpark && st_q == PORT_PARKED)
      st_d = PORT_ARMED;
    else if (st_q == PORT_ARMED && rti)
      st_d = PORT_LIVE;
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= PORT_PARKED;
    else     st_q <= st_d;
  end

  assign live = (st_q == PORT_LIVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      tms_q    <= 1'b1;
      tck_en_q <= 1'b0;
    end else begin
      tms_q    <= live ? tms_in : 1'b1;
      tck_en_q <= live;
    end
  end
endmodule

// File: rtl/scb_path.sv
module scb_path #(
  parameter int NPORTS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPORTS-1:0] live,
  input  logic              tdi_in,
  input  logic [NPORTS-1:0] chain_tdo,
  input  logic              mode_path,
  input  logic              mode_lsb,
  output logic [NPORTS-1:0] loc_tdi,
  output logic              ret_tdo
);
  logic [NPORTS-1:0] src;
  logic [NPORTS:0]   carry;
  logic              byp_q;
  logic              ret_d;

  assign carry[0] = tdi_in;

  for (genvar i = 0; i < NPORTS; i++) begin : g_link
    assign src[i]     = live[i] ? carry[i] : 1'b1;
    assign carry[i+1] = live[i] ? chain_tdo[i] : carry[i];
  end

  always_comb begin
    if (mode_path)
      ret_d = mode_lsb;
    else if (|live)
      ret_d = carry[NPORTS];
    else
      ret_d = byp_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loc_tdi <= '1;
      ret_tdo <= 1'b1;
      byp_q   <= 1'b1;
    end else begin
      loc_tdi <= src;
      ret_tdo <= ret_d;
      byp_q   <= tdi_in;
    end
  end
endmodule

// File: rtl/scan_branch_ctrl.sv
module scan_branch_ctrl
  import scb_pkg::*;
#(
  parameter int NPORTS = 3,
  parameter int MODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        tap_state,
  input  logic              sel,
  input  logic              ir_modesel,
  input  logic              upd_unpark,
  input  logic              upd_park,
  input  logic              upd_wait,
  input  logic              tms_in,
  input  logic              tdi_in,
  input  logic [NPORTS-1:0] chain_tdo,
  output logic [NPORTS-1:0] loc_tms,
  output logic [NPORTS-1:0] loc_tck_en,
  output logic [NPORTS-1:0] loc_tdi,
  output logic              ret_tdo
);
  logic              tlr, rti, mode_act, go_park, go_unpark, sh_lsb;
  logic [MODE_W-1:0] mode_q;
  logic [NPORTS-1:0] live;

  assign tlr       = (tap_state == TAP_TLR);
  assign rti       = (tap_state == TAP_RTI);
  assign mode_act  = sel && ir_modesel;
  assign go_park   = sel && (upd_park || upd_wait);
  assign go_unpark = sel && upd_unpark;

  scb_mode #(.MODE_W(MODE_W)) i_mode (
    .clk    (clk),
    .rst    (rst),
    .tlr    (tlr),
    .act    (mode_act),
    .cap    (tap_state == TAP_CDR),
    .shf    (tap_state == TAP_SDR),
    .upd    (tap_state == TAP_UDR),
    .tdi    (tdi_in),
    .mode_q (mode_q),
    .sh_lsb (sh_lsb)
  );

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    scb_port i_port (
      .clk       (clk),
      .rst       (rst),
      .tlr       (tlr),
      .rti       (rti),
      .en        (mode_q[i]),
      .go_unpark (go_unpark),
      .go_park   (go_park),
      .tms_in    (tms_in),
      .live      (live[i]),
      .tms_q     (loc_tms[i]),
      .tck_en_q  (loc_tck_en[i])
    );
  end

  scb_path #(.NPORTS(NPORTS)) i_path (
    .clk       (clk),
    .rst       (rst),
    .live      (live),
    .tdi_in    (tdi_in),
    .chain_tdo (chain_tdo),
    .mode_path (mode_act),
    .mode_lsb  (sh_lsb),
    .loc_tdi   (loc_tdi),
    .ret_tdo   (ret_tdo)
  );
endmodule

// File: rtl/scan_branch_ctrl_chk.sv
module scan_branch_ctrl_chk #(
  parameter int NPORTS = 3,
  parameter int MODE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        tap_state,
  input logic              sel,
  input logic              ir_modesel,
  input logic              upd_park,
  input logic              upd_wait,
  input logic [NPORTS-1:0] loc_tms,
  input logic [NPORTS-1:0] loc_tck_en,
  input logic [MODE_W-1:0] mode_q
);
  assert_reset_parks_R1: assert property (@(posedge clk)
    rst |=> (&loc_tms) && (loc_tck_en == '0));

  assert_idle_port_tms_high_R5: assert property (@(posedge clk) disable iff (rst)
    ((~loc_tck_en) & (~loc_tms)) == '0);

  assert_mode_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (tap_state != 4'hF) && !(sel && ir_modesel && tap_state == 4'h5) |=> $stable(mode_q));

  assert_mode_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (tap_state == 4'hF) |=> (mode_q == '0));

  assert_park_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    $past(sel && (upd_park || upd_wait), 2) |-> (loc_tck_en == '0));

  assert_live_after_idle_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(loc_tck_en[0]) |-> ($past(tap_state, 2) == 4'hC));
endmodule

bind scan_branch_ctrl scan_branch_ctrl_chk #(.NPORTS(NPORTS), .MODE_W(MODE_W)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .tap_state  (tap_state),
  .sel        (sel),
  .ir_modesel (ir_modesel),
  .upd_park   (upd_park),
  .upd_wait   (upd_wait),
  .loc_tms    (loc_tms),
  .loc_tck_en (loc_tck_en),
  .mode_q     (mode_q)
);

// File: tb/test_scan_branch_ctrl.sv
`timescale 1ns/1ps
module test_scan_branch_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] tap_state = 4'hC;
  logic       sel = 1'b0, ir_modesel = 1'b0;
  logic       upd_unpark = 1'b0, upd_park = 1'b0, upd_wait = 1'b0;
  logic       tms_in = 1'b1, tdi_in = 1'b1;
  logic [2:0] chain_tdo = 3'b111;
  logic [2:0] loc_tms, loc_tck_en, loc_tdi;
  logic       ret_tdo;

  int compared = 0, mismatched = 0, cycles = 0;

  always #2 clk = ~clk;

  scan_branch_ctrl i_scan_branch_ctrl (
    .clk(clk), .rst(rst), .tap_state(tap_state), .sel(sel), .ir_modesel(ir_modesel),
    .upd_unpark(upd_unpark), .upd_park(upd_park), .upd_wait(upd_wait),
    .tms_in(tms_in), .tdi_in(tdi_in), .chain_tdo(chain_tdo),
    .loc_tms(loc_tms), .loc_tck_en(loc_tck_en), .loc_tdi(loc_tdi), .ret_tdo(ret_tdo)
  );

  // behavioural reference: port states 0 parked, 1 armed, 2 live
  int         m_st [3];
  logic [7:0] m_mode, m_sh;
  logic       m_byp, e_ret;
  logic [2:0] e_tms, e_en, e_tdi;

  always @(posedge clk) begin
    logic carry, any;
    if (rst) begin
      foreach (m_st[i]) m_st[i] = 0;
      m_mode = 0; m_sh = 0; m_byp = 1;
      e_tms = 3'b111; e_en = 0; e_tdi = 3'b111; e_ret = 1;
    end else begin
      carry = tdi_in; any = 0;
      for (int i = 0; i < 3; i++) begin
        e_tms[i] = (m_st[i] == 2) ? tms_in : 1'b1;
        e_en[i]  = (m_st[i] == 2);
        e_tdi[i] = (m_st[i] == 2) ? carry : 1'b1;
        if (m_st[i] == 2) begin carry = chain_tdo[i]; any = 1; end
      end
      e_ret = (sel && ir_modesel) ? m_sh[0] : (any ? carry : m_byp);
      m_byp = tdi_in;
      for (int i = 0; i < 3; i++) begin
        if (tap_state == 4'hF || !m_mode[i] || (sel && (upd_park || upd_wait))) m_st[i] = 0;
        else if (sel && upd_unpark && m_st[i] == 0) m_st[i] = 1;
        else if (m_st[i] == 1 && tap_state == 4'hC) m_st[i] = 2;
      end
      if (tap_state == 4'hF) m_mode = 0;
      else if (sel && ir_modesel) begin
        if (tap_state == 4'h6) m_sh = m_mode;
        else if (tap_state == 4'h2) m_sh = {tdi_in, m_sh[7:1]};
        else if (tap_state == 4'h5) m_mode = m_sh;
      end
    end
  end

  always @(negedge clk) begin
    if (cycles > 0) begin
      compared++;
      if (loc_tms !== e_tms || loc_tck_en !== e_en || loc_tdi !== e_tdi || ret_tdo !== e_ret) begin
        mismatched++;
        $display("FAIL R4 R5 R6 R7 per-cycle: tms %b/%b en %b/%b tdi %b/%b ret %b/%b (actual/expected)",
                 loc_tms, e_tms, loc_tck_en, e_en, loc_tdi, e_tdi, ret_tdo, e_ret);
      end
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung, expected completion");
      finish_run();
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // scan mode register: returns old value, leaves new value
  task automatic scan_mode(input logic [7:0] nv, output logic [7:0] old);
    ir_modesel = 1; tap_state = 4'h6; tick();
    tap_state = 4'h2;
    for (int k = 0; k < 8; k++) begin
      tdi_in = nv[k]; tick(); old[k] = ret_tdo;
    end
    tap_state = 4'h5; tick();
    ir_modesel = 0; tap_state = 4'h7;
  endtask

  task automatic pulse(ref logic s);
    s = 1; tick(); s = 0;
  endtask

  task automatic unpark_all();
    pulse(upd_unpark); tap_state = 4'h7; tick();
    tap_state = 4'hC; tick(2);
  endtask

  task automatic random_run(int n);
    logic [3:0] taps [5] = '{4'hC, 4'h2, 4'h6, 4'h5, 4'h7};
    for (int k = 0; k < n; k++) begin
      tap_state = taps[$urandom_range(0, 4)];
      tms_in = 1'($urandom); tdi_in = 1'($urandom); chain_tdo = 3'($urandom);
      tick();
    end
    tap_state = 4'h7;
  endtask

  initial begin
    logic [7:0] old;
    tick(3); rst = 0; tick();
    chk("R1 loc_tms after reset", {5'd0, loc_tms}, 8'h07);
    chk("R1 loc_tck_en after reset", {5'd0, loc_tck_en}, 8'h00);
    chk("R1 ret_tdo after reset", {7'd0, ret_tdo}, 8'h01);

    sel = 1;
    scan_mode(8'h07, old);
    chk("R1 mode cleared by reset", old, 8'h00);
    unpark_all();
    chk("R4 all three live", {5'd0, loc_tck_en}, 8'h07);
    random_run(200);
    chk("R6 ret follows port2 tdo", {7'd0, ret_tdo}, {7'd0, e_ret});

    pulse(upd_park); tick(2);
    chk("R8 park clears tck_en", {5'd0, loc_tck_en}, 8'h00);
    chk("R8 park drives tms high", {5'd0, loc_tms}, 8'h07);

    scan_mode(8'h05, old);
    chk("R2 readback of 0x07", old, 8'h07);
    unpark_all();
    chk("R5 port1 skipped", {5'd0, loc_tck_en}, 8'h05);
    random_run(200);

    scan_mode(8'h04, old);
    tick(2);
    chk("R10 port0 parked by mode clear", {5'd0, loc_tck_en}, 8'h04);

    sel = 0;
    pulse(upd_wait); pulse(upd_park); tick(2);
    chk("R9 strobes ignored unselected", {5'd0, loc_tck_en}, 8'h04);
    scan_mode(8'hA3, old);
    sel = 1;
    pulse(upd_wait); tick(2);
    chk("R8 wait parks all", {5'd0, loc_tck_en}, 8'h00);

    tdi_in = 1; tick(); tdi_in = 0; tick();
    chk("R7 bypass two edges", {7'd0, ret_tdo}, 8'h01);
    tick();
    chk("R7 bypass two edges low", {7'd0, ret_tdo}, 8'h00);
    random_run(100);

    scan_mode(8'h04, old);
    chk("R9 R2 mode unchanged by unselected scan", old, 8'h04);
    sel = 0; tick(5); sel = 1;
    scan_mode(8'h04, old);
    chk("R3 mode kept across unselect", old, 8'h04);
    unpark_all();
    tap_state = 4'hF; tick(); tap_state = 4'hC; tick(2);
    chk("R8 TLR parks ports", {5'd0, loc_tck_en}, 8'h00);
    scan_mode(8'h00, old);
    chk("R3 TLR clears mode", old, 8'h00);

    tick(3);
    finish_run();
  end
endmodule